// File: doc/BRIEF.md
# Seeded Random-Address Byte Permuter

This block scrambles a block of bytes by moving them to new positions. It does not change their values. A maximal-length linear feedback shift register is loaded with a secret nonzero seed. It then yields one pseudo-random address per byte, and that address goes straight onto the address lines of a destination memory. In store mode, byte k of a local byte buffer is written into the destination memory at the k-th generated address. In load mode, the same walk reads the destination memory at the k-th address and puts that byte back into buffer position k. A store followed by a load with the same seed therefore returns the original block. The seed is the only key material, and the generated addresses are never exported as data.

Transfers stream at one byte per clock cycle once a start pulse is accepted. Two users can share one physical destination memory. A half-select input, latched at start, becomes the top address bit, so each user works in its own logical half. A zero seed would lock the register, so it is refused with an error flag. With the default 4-bit register a block holds up to 15 bytes, which use addresses 0 to 14 of a 16-byte logical half.

Top module: `rand_addr_permuter`

## Requirements
- R1: After reset, busy, done and seed_err are low, and neither pbuf_we nor mem_we is asserted.
- R2: The address register steps as a right-shifting Galois LFSR: when bit 0 is 1 the next state is (state>>1) XOR mask, otherwise it is state>>1. The mask is 0xC for AW=4. The register is loaded with seed when start is accepted and advances once per transferred byte. The low AW bits of mem_addr equal state minus 1, so seed 4 sends the first byte to address 3.
- R3: In store mode (op_load=0), busy cycle k drives pbuf_addr=k and writes pbuf_rdata into the destination memory at the k-th generated address. pbuf_we stays low.
- R4: In load mode (op_load=1), busy cycle k reads the destination memory at the k-th generated address and writes that byte into buffer position k. mem_we stays low. A load after a store with the same seed and length restores the original buffer.
- R5: busy is high for exactly blk_len cycles, starting the cycle after start is sampled. done is a single-cycle pulse in the first cycle after busy falls.
- R6: Within one block no destination address is written twice. A full block of 2^AW-1 bytes covers addresses 0 to 2^AW-2.
- R7: half_sel, latched at start, drives mem_addr bit AW for the whole block. The other half of the destination memory is not written.
- R8: A start with seed equal to zero sets seed_err the next cycle. It causes no transfer and no done pulse. The next accepted start clears seed_err.
- R9: A start with a nonzero seed and blk_len equal to zero produces a done pulse the next cycle with no transfer.
- R10: start is ignored while busy is high. Mode, seed, length and half_sel are all taken at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a block when idle |
| op_load | input | 1 | 0 = scatter buffer to memory, 1 = gather memory to buffer |
| half_sel | input | 1 | Logical half of the destination memory |
| seed | input | AW | Nonzero LFSR initial value (the key) |
| blk_len | input | AW | Bytes in the block, 0 to 2^AW-1 |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| seed_err | output | 1 | Last start was refused for a zero seed |
| pbuf_addr | output | AW | Byte buffer address (position k) |
| pbuf_rdata | input | DW | Byte buffer read data, combinational |
| pbuf_we | output | 1 | Byte buffer write enable (load mode) |
| pbuf_wdata | output | DW | Byte buffer write data |
| mem_addr | output | AW+1 | Destination memory address, top bit is the half |
| mem_rdata | input | DW | Destination memory read data, combinational |
| mem_we | output | 1 | Destination memory write enable (store mode) |
| mem_wdata | output | DW | Destination memory write data |

## Verification
The assertions take for granted that both memories return read data in the same cycle the address is presented. They also assume that start, seed and blk_len are settled before the sampling edge, and that the seed stays at or below the register's range. The bench models the memories as combinational-read arrays written on the clock edge. It changes every input only on the falling edge, and it uses only 4-bit seeds and lengths, so every stimulus stays inside those assumptions. Under these conditions the checks on address range, distinct consecutive addresses and a stable half bit reflect the LFSR behaviour and not stray input timing.

// File: rtl/rand_addr_permuter.sv
module rand_addr_permuter #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_load,
  input  logic          half_sel,
  input  logic [AW-1:0] seed,
  input  logic [AW-1:0] blk_len,
  output logic          busy,
  output logic          done,
  output logic          seed_err,
  output logic [AW-1:0] pbuf_addr,
  input  logic [DW-1:0] pbuf_rdata,
  output logic          pbuf_we,
  output logic [DW-1:0] pbuf_wdata,
  output logic [AW:0]   mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata
);

  function automatic logic [11:0] tap_mask(input int w);
    case (w)
      3:       return 12'h006;
      4:       return 12'h00C;
      5:       return 12'h014;
      6:       return 12'h030;
      7:       return 12'h060;
      8:       return 12'h0B8;
      9:       return 12'h110;
      10:      return 12'h240;
      11:      return 12'h500;
      default: return 12'hE08;
    endcase
  endfunction

  localparam logic [11:0]   MASK_W = tap_mask(AW);
  localparam logic [AW-1:0] TAPS   = MASK_W[AW-1:0];
  localparam logic [AW-1:0] ONE    = AW'(1);

  logic          busy_q, done_q, err_q, load_q, half_q;
  logic [AW-1:0] lfsr_q, idx_q, last_q;
  logic [AW-1:0] lfsr_nxt;

  assign lfsr_nxt = lfsr_q[0] ? ((lfsr_q >> 1) ^ TAPS) : (lfsr_q >> 1);

  assign busy       = busy_q;
  assign done       = done_q;
  assign seed_err   = err_q;
  assign mem_addr   = {half_q, lfsr_q - ONE};
  assign mem_we     = busy_q & ~load_q;
  assign mem_wdata  = pbuf_rdata;
  assign pbuf_addr  = idx_q;
  assign pbuf_we    = busy_q & load_q;
  assign pbuf_wdata = mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      load_q <= 1'b0;
      half_q <= 1'b0;
      lfsr_q <= ONE;
      idx_q  <= '0;
      last_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        lfsr_q <= lfsr_nxt;
        idx_q  <= idx_q + ONE;
        if (idx_q == last_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (start) begin
        if (seed == '0) begin
          err_q <= 1'b1;
        end else begin
          err_q  <= 1'b0;
          load_q <= op_load;
          half_q <= half_sel;
          lfsr_q <= seed;
          idx_q  <= '0;
          last_q <= blk_len - ONE;
          if (blk_len == '0) done_q <= 1'b1;
          else               busy_q <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/rand_addr_permuter_chk.sv
module rand_addr_permuter_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW-1:0] seed,
  input logic          busy,
  input logic          done,
  input logic          seed_err,
  input logic [AW:0]   mem_addr
);

  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_addr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mem_addr[AW-1:0] != '1));

  p_addr_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (mem_addr != $past(mem_addr)));

  p_half_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mem_addr[AW]));

  p_zero_seed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && seed == '0) |=> (seed_err && !busy && !done));

endmodule

bind rand_addr_permuter rand_addr_permuter_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .seed(seed), .busy(busy),
  .done(done), .seed_err(seed_err), .mem_addr(mem_addr)
);

// File: tb/sim_rand_addr_permuter.sv
`timescale 1ns/1ps
module sim_rand_addr_permuter;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, op_load = 1'b0, half_sel = 1'b0;
  logic [AW-1:0] seed = '0, blk_len = '0;
  logic busy, done, seed_err, pbuf_we, mem_we;
  logic [AW-1:0] pbuf_addr;
  logic [AW:0]   mem_addr;
  logic [DW-1:0] pbuf_rdata, pbuf_wdata, mem_rdata, mem_wdata;

  logic [DW-1:0] pmem [N];
  logic [DW-1:0] dmem [2*N];
  logic [DW-1:0] orig [N];
  int wr_cnt [2*N];
  int nchk = 0, nerr = 0;
  int cycles;
  logic done_seen;

  always #2.5 clk = ~clk;

  rand_addr_permuter #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_load(op_load),
    .half_sel(half_sel), .seed(seed), .blk_len(blk_len), .busy(busy),
    .done(done), .seed_err(seed_err), .pbuf_addr(pbuf_addr),
    .pbuf_rdata(pbuf_rdata), .pbuf_we(pbuf_we), .pbuf_wdata(pbuf_wdata),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_we(mem_we),
    .mem_wdata(mem_wdata)
  );

  assign pbuf_rdata = pmem[pbuf_addr];
  assign mem_rdata  = dmem[mem_addr];

  always @(posedge clk) begin
    if (pbuf_we) pmem[pbuf_addr] <= pbuf_wdata;
    if (mem_we) begin
      dmem[mem_addr] <= mem_wdata;
      wr_cnt[mem_addr] <= wr_cnt[mem_addr] + 1;
    end
  end

  function automatic logic [AW-1:0] step(input logic [AW-1:0] s);
    return s[0] ? ((s >> 1) ^ 4'hC) : (s >> 1);
  endfunction

  function automatic int addr_k(input logic [AW-1:0] s0, input int k);
    logic [AW-1:0] s = s0;
    for (int i = 0; i < k; i++) s = step(s);
    return int'(s) - 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_dest();
    for (int i = 0; i < 2*N; i++) begin dmem[i] = 8'h00; wr_cnt[i] = 0; end
  endtask

  function automatic int total_writes(input int lo, input int hi);
    int t = 0;
    for (int i = lo; i < hi; i++) t += wr_cnt[i];
    return t;
  endfunction

  task automatic wait_end();
    cycles = 0;
    while (busy && cycles < 100) begin cycles++; @(negedge clk); end
    done_seen = done;
  endtask

  task automatic run(input logic ld, input logic [AW-1:0] sd,
                     input logic [AW-1:0] ln, input logic hs);
    @(negedge clk);
    op_load = ld; seed = sd; blk_len = ln; half_sel = hs; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_end();
  endtask

  function automatic int store_mism(input logic [AW-1:0] sd, input int ln, input int base);
    int m = 0;
    for (int k = 0; k < ln; k++)
      if (dmem[base + addr_k(sd, k)] != pmem[k]) m++;
    return m;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 seed_err", int'(seed_err), 0);
    chk("R1 strobes", int'(mem_we | pbuf_we), 0);
  endtask

  task automatic t_store_full();
    int dup = 0;
    for (int i = 0; i < N; i++) begin pmem[i] = DW'(i*17 + 5); orig[i] = DW'(i*17 + 5); end
    clear_dest();
    run(1'b0, 4'd4, 4'd15, 1'b0);
    chk("R5 busy cycles", cycles, 15);
    chk("R5 done pulse", int'(done_seen), 1);
    @(negedge clk);
    chk("R5 done single", int'(done), 0);
    chk("R2 first byte at addr 3", int'(dmem[3]), int'(pmem[0]));
    chk("R3 store placement", store_mism(4'd4, 15, 0), 0);
    for (int i = 0; i < N; i++) if (wr_cnt[i] > 1) dup++;
    chk("R6 no double write", dup, 0);
    chk("R6 full coverage", total_writes(0, N-1), 15);
    chk("R6 top slot unused", wr_cnt[N-1], 0);
    chk("R7 other half untouched", total_writes(N, 2*N), 0);
    chk("R3 buffer unchanged", int'(pmem[7]), int'(orig[7]));
  endtask

  task automatic t_load_back();
    int m = 0;
    for (int i = 0; i < N; i++) pmem[i] = 8'h00;
    for (int i = 0; i < 2*N; i++) wr_cnt[i] = 0;
    run(1'b1, 4'd4, 4'd15, 1'b0);
    chk("R4 load cycles", cycles, 15);
    for (int k = 0; k < 15; k++) if (pmem[k] != orig[k]) m++;
    chk("R4 round trip", m, 0);
    chk("R4 no memory write", total_writes(0, 2*N), 0);
  endtask

  task automatic t_half();
    for (int i = 0; i < N; i++) pmem[i] = orig[i];
    clear_dest();
    run(1'b0, 4'd9, 4'd15, 1'b1);
    chk("R7 upper half placement", store_mism(4'd9, 15, N), 0);
    chk("R7 lower half untouched", total_writes(0, N), 0);
  endtask

  task automatic t_zero_seed();
    clear_dest();
    run(1'b0, 4'd0, 4'd6, 1'b0);
    chk("R8 error flag", int'(seed_err), 1);
    chk("R8 no busy", cycles, 0);
    chk("R8 no done", int'(done_seen), 0);
    chk("R8 no writes", total_writes(0, 2*N), 0);
  endtask

  task automatic t_len_zero();
    clear_dest();
    run(1'b0, 4'd5, 4'd0, 1'b0);
    chk("R9 done", int'(done_seen), 1);
    chk("R9 no busy", cycles, 0);
    chk("R9 no writes", total_writes(0, 2*N), 0);
    chk("R8 error cleared", int'(seed_err), 0);
  endtask

  task automatic t_short();
    clear_dest();
    run(1'b0, 4'd7, 4'd5, 1'b0);
    chk("R5 short cycles", cycles, 5);
    chk("R3 short placement", store_mism(4'd7, 5, 0), 0);
    chk("R6 short writes", total_writes(0, 2*N), 5);
  endtask

  task automatic t_start_busy();
    clear_dest();
    @(negedge clk);
    op_load = 1'b0; seed = 4'd4; blk_len = 4'd15; half_sel = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    op_load = 1'b1; seed = 4'd9; half_sel = 1'b1; blk_len = 4'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_end();
    chk("R10 cycles unchanged", cycles + 4, 15);
    chk("R10 first start kept", store_mism(4'd4, 15, 0), 0);
    chk("R10 write count", total_writes(0, 2*N), 15);
  endtask

  initial begin
    #(2.5ns * 2 * 150000);
    nerr++; nchk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) pmem[i] = 8'h00;
    clear_dest();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_store_full();
    t_load_back();
    t_half();
    t_zero_seed();
    t_len_zero();
    t_short();
    t_start_busy();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule